// File: doc/BRIEF.md
# Byte/Word Switchable Read-Only Memory Read Port

This block models the read-side control of a 16-bit-wide non-volatile memory that can also be read as a memory of twice the depth and half the width. A chip enable, an output enable, a width-select input and a high-voltage-detect flag are decoded into one of six named states. From that state the block drives a 16-bit data bus split into two byte lanes, and each lane has its own output-enable. In half-width reads, an extra least-significant address input selects which half of the addressed word appears on the low lane. In the identifier state the block returns fixed manufacturer and device codes in place of array contents.

The storage is an internal register array. The environment fills it through a simple write port before reading. Inputs are sampled at each rising clock edge, so the outputs show the decode and data of the previous edge. Electrical behaviour, access timing and programming are not modelled.

States, decoded every cycle with the priority given:

- `ST_STANDBY`: chip enable is high.
- `ST_QUIET`: chip enable is low and output enable is high.
- `ST_ID_WORD` / `ST_ID_BYTE`: both enables are low and the high-voltage flag is set. Width select picks between the two.
- `ST_BYTE`: both enables are low, the flag is clear and half-width is selected.
- `ST_WORD`: both enables are low, the flag is clear and full width is selected.

Every state can move to every other state in one cycle, so each transition is simply "the inputs now decode to state X". Reset puts the block in `ST_STANDBY`.

Top module: `bw_rom_read`

## Requirements
- R1: With chip enable high (`ce_ni`=1), one cycle later both lane enables are 0, whatever the other inputs are.
- R2: With chip enable low and output enable high, one cycle later both lane enables are 0.
- R3: In a full-width read, one cycle later both lane enables are 1 and `data_o` equals the stored word at `addr_i`.
- R4: In a half-width read (`byte_mode_i`=1) with `addr_lsb_i`=0, one cycle later `lane_oe_o`=2'b01, `data_o[7:0]` is bits 7:0 of the addressed word, and `data_o[15:8]` is 0.
- R5: In a half-width read with `addr_lsb_i`=1, one cycle later `lane_oe_o`=2'b01 and `data_o[7:0]` is bits 15:8 of the addressed word.
- R6: In identifier mode at full width, with all address bits above bit 0 at zero, `data_o` is 16'h00C2 when `addr_i[0]`=0 and 16'h0115 when `addr_i[0]`=1. Both lanes are enabled and the array contents have no effect.
- R7: In identifier mode at half width, only lane 0 is enabled. The manufacturer code gives 8'hC2 when `addr_lsb_i`=0 and 8'h00 when it is 1. The device code gives 8'h12 when `addr_lsb_i`=0 and 8'h01 when it is 1.
- R8: In identifier mode with any address bit above bit 0 set, the enabled lanes carry all ones: 16'hFFFF at full width, 8'hFF on lane 0 at half width.
- R9: After reset, and until the first edge that samples a different decode, both lanes are off. Outputs change only at a rising clock edge.
- R10: A write with `load_en_i`=1 stores `load_data_i` at `load_addr_i`. A read sampled at any later edge returns the new word.
- R11: A lane whose enable is 0 drives zeros on its data bits. Lane 1 is never enabled while lane 0 is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| byte_mode_i | input | 1 | 1 selects half-width (byte) reads |
| id_hv_i | input | 1 | High-voltage detect flag; 1 requests identifier codes |
| addr_i | input | ADDR_W | Word address |
| addr_lsb_i | input | 1 | Half select in byte mode: 1 picks the upper byte |
| load_en_i | input | 1 | Array preload write strobe |
| load_addr_i | input | ADDR_W | Preload word address |
| load_data_i | input | DATA_W | Preload word |
| data_o | output | DATA_W | Data bus, two byte lanes |
| lane_oe_o | output | 2 | Per-lane drive enable; bit 0 covers bits 7:0 |

## Verification
The bench builds the block with `ADDR_W`=4, a 16-word array. At that size every address can be read in full-width mode and in both byte halves after a distinct computed preload. In identifier mode, each upper address bit can be set on its own to check the all-ones response, and every combination of identifier select, width and half can be covered. Standby and output-disable are applied across the sweep with varying data underneath. A late overwrite shows that the array update and the latency are seen at the ports.

// File: rtl/bw_rom_pkg.sv
package bw_rom_pkg;
    typedef enum logic [2:0] {
        ST_STANDBY = 3'd0,
        ST_QUIET   = 3'd1,
        ST_WORD    = 3'd2,
        ST_BYTE    = 3'd3,
        ST_ID_WORD = 3'd4,
        ST_ID_BYTE = 3'd5
    } rd_state_e;
endpackage

// File: rtl/bw_rom_mode_fsm.sv
module bw_rom_mode_fsm
    import bw_rom_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ce_ni,
    input  logic              oe_ni,
    input  logic              byte_mode_i,
    input  logic              id_hv_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              addr_lsb_i,
    output rd_state_e         state_o,
    output logic              a0_o,
    output logic              lsb_o,
    output logic              id_ok_o
);
    rd_state_e state_q, state_d;
    logic      a0_q, lsb_q, id_ok_q;

    // Decode priority: chip enable, output enable, identifier flag, width
    always_comb begin
        if (ce_ni)
            state_d = ST_STANDBY;
        else if (oe_ni)
            state_d = ST_QUIET;
        else if (id_hv_i)
            state_d = byte_mode_i ? ST_ID_BYTE : ST_ID_WORD;
        else
            state_d = byte_mode_i ? ST_BYTE : ST_WORD;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_STANDBY;
            a0_q    <= 1'b0;
            lsb_q   <= 1'b0;
            id_ok_q <= 1'b0;
        end else begin
            state_q <= state_d;
            a0_q    <= addr_i[0];
            lsb_q   <= addr_lsb_i;
            id_ok_q <= (addr_i[ADDR_W-1:1] == '0);
        end
    end

    assign state_o = state_q;
    assign a0_o    = a0_q;
    assign lsb_o   = lsb_q;
    assign id_ok_o = id_ok_q;
endmodule

// File: rtl/bw_rom_store.sv
module bw_rom_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
        if (wr_en_i)
            mem_q[wr_addr_i] <= wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            rd_q <= '0;
        else
            rd_q <= mem_q[rd_addr_i];
    end

    assign rd_data_o = rd_q;
endmodule

// File: rtl/bw_rom_lane_mux.sv
module bw_rom_lane_mux
    import bw_rom_pkg::*;
#(
    parameter int              DATA_W      = 16,
    parameter logic [DATA_W-1:0] MFR_CODE  = 16'h00C2,
    parameter logic [DATA_W-1:0] DEV_CODE  = 16'h0115,
    parameter logic [DATA_W/2-1:0] DEV_BYTE_LO = 8'h12
) (
    input  rd_state_e         state_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              a0_i,
    input  logic              lsb_i,
    input  logic              id_ok_i,
    output logic [DATA_W-1:0] data_o,
    output logic [1:0]        lane_oe_o
);
    localparam int LANE_W = DATA_W / 2;

    logic [DATA_W-1:0] id_word;
    logic [LANE_W-1:0] id_byte;
    logic [LANE_W-1:0] half;

    always_comb begin
        if (!id_ok_i)
            id_word = '1;
        else
            id_word = a0_i ? DEV_CODE : MFR_CODE;

        if (!id_ok_i)
            id_byte = '1;
        else if (a0_i)
            id_byte = lsb_i ? DEV_CODE[DATA_W-1:LANE_W] : DEV_BYTE_LO;
        else
            id_byte = lsb_i ? MFR_CODE[DATA_W-1:LANE_W] : MFR_CODE[LANE_W-1:0];

        half = lsb_i ? word_i[DATA_W-1:LANE_W] : word_i[LANE_W-1:0];
    end

    always_comb begin
        data_o    = '0;
        lane_oe_o = 2'b00;
        unique case (state_i)
            ST_STANDBY, ST_QUIET: begin
                data_o    = '0;
                lane_oe_o = 2'b00;
            end
            ST_WORD: begin
                data_o    = word_i;
                lane_oe_o = 2'b11;
            end
            ST_BYTE: begin
                data_o    = {{LANE_W{1'b0}}, half};
                lane_oe_o = 2'b01;
            end
            ST_ID_WORD: begin
                data_o    = id_word;
                lane_oe_o = 2'b11;
            end
            ST_ID_BYTE: begin
                data_o    = {{LANE_W{1'b0}}, id_byte};
                lane_oe_o = 2'b01;
            end
            default: begin
                data_o    = '0;
                lane_oe_o = 2'b00;
            end
        endcase
    end
endmodule

// File: rtl/bw_rom_read.sv
module bw_rom_read
    import bw_rom_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ce_ni,
    input  logic              oe_ni,
    input  logic              byte_mode_i,
    input  logic              id_hv_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              addr_lsb_i,
    input  logic              load_en_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic [DATA_W-1:0] load_data_i,
    output logic [DATA_W-1:0] data_o,
    output logic [1:0]        lane_oe_o
);
    localparam int LANE_W = DATA_W / 2;

    rd_state_e         state;
    logic              a0, lsb, id_ok;
    logic [DATA_W-1:0] word;

    bw_rom_mode_fsm #(.ADDR_W(ADDR_W)) fsm_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ce_ni       (ce_ni),
        .oe_ni       (oe_ni),
        .byte_mode_i (byte_mode_i),
        .id_hv_i     (id_hv_i),
        .addr_i      (addr_i),
        .addr_lsb_i  (addr_lsb_i),
        .state_o     (state),
        .a0_o        (a0),
        .lsb_o       (lsb),
        .id_ok_o     (id_ok)
    );

    bw_rom_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (load_en_i),
        .wr_addr_i (load_addr_i),
        .wr_data_i (load_data_i),
        .rd_addr_i (addr_i),
        .rd_data_o (word)
    );

    bw_rom_lane_mux #(.DATA_W(DATA_W)) mux_i (
        .state_i   (state),
        .word_i    (word),
        .a0_i      (a0),
        .lsb_i     (lsb),
        .id_ok_i   (id_ok),
        .data_o    (data_o),
        .lane_oe_o (lane_oe_o)
    );

    // R1
    standby_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ce_ni |=> lane_oe_o == 2'b00);

    // R2
    out_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ce_ni && oe_ni) |=> lane_oe_o == 2'b00);

    // R3
    word_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ce_ni && !oe_ni && !id_hv_i && !byte_mode_i) |=> lane_oe_o == 2'b11);

    // R4
    byte_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ce_ni && !oe_ni && byte_mode_i) |=>
            (lane_oe_o == 2'b01 && data_o[DATA_W-1:LANE_W] == '0));

    // R8
    id_bad_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ce_ni && !oe_ni && id_hv_i && !byte_mode_i && addr_i[ADDR_W-1:1] != '0)
            |=> data_o == '1);

    // R11
    lane_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(lane_oe_o[1] && !lane_oe_o[0]));
endmodule

// File: tb/bw_rom_read_tb_top.sv
module bw_rom_read_tb_top;
    localparam int AW = 4;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, byte_m = 1'b0, hv = 1'b0, lsb = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic [DW-1:0] data;
    logic [1:0]    oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    bw_rom_read #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n),
        .byte_mode_i(byte_m), .id_hv_i(hv), .addr_i(addr), .addr_lsb_i(lsb),
        .load_en_i(ld_en), .load_addr_i(ld_addr), .load_data_i(ld_data),
        .data_o(data), .lane_oe_o(oe));

    function automatic logic [DW-1:0] pat(int a);
        return DW'((a * 16'h3A7 + 16'h1C5) ^ 16'h8421);
    endfunction

    task automatic chk(string req, logic [DW-1:0] ed, logic [1:0] eo);
        n_chk++;
        if (data !== ed || oe !== eo) begin
            n_bad++;
            $display("FAIL %s: data=%h oe=%b expected data=%h oe=%b", req, data, oe, ed, eo);
        end
    endtask

    task automatic drive(logic c, logic o, logic b, logic h, int a, logic l);
        @(negedge clk);
        ce_n = c; oe_n = o; byte_m = b; hv = h; addr = AW'(a); lsb = l;
        @(posedge clk);
        #1;
    endtask

    task automatic load(int a, logic [DW-1:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = AW'(a); ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    initial begin
        #150000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: data=%h oe=%b expected completion", data, oe);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset", '0, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < (1 << AW); a++) load(a, pat(a));
        @(posedge clk); #1;
        chk("R9 idle after reset", '0, 2'b00);

        // R9: a new decode is not visible before the sampling edge
        @(negedge clk);
        ce_n = 0; oe_n = 0; byte_m = 0; hv = 0; addr = '0; lsb = 0;
        #1;
        chk("R9 before edge", '0, 2'b00);
        @(posedge clk); #1;
        chk("R3 first read", pat(0), 2'b11);

        for (int a = 0; a < (1 << AW); a++) begin
            logic [DW-1:0] w;
            w = pat(a);
            drive(0, 0, 0, 0, a, a[0]);
            chk("R3 word read", w, 2'b11);
            drive(0, 0, 1, 0, a, 0);
            chk("R4 low half", {8'h00, w[7:0]}, 2'b01);
            drive(0, 0, 1, 0, a, 1);
            chk("R5 high half", {8'h00, w[15:8]}, 2'b01);
            drive(1, a[0], a[1], a[2], a, a[3]);
            chk("R1 standby", '0, 2'b00);
            drive(0, 1, a[1], a[2], a, a[3]);
            chk("R2 output disable", '0, 2'b00);
        end

        // identifier codes, array ignored
        drive(0, 0, 0, 1, 0, 0);
        chk("R6 mfr word", 16'h00C2, 2'b11);
        drive(0, 0, 0, 1, 1, 1);
        chk("R6 dev word", 16'h0115, 2'b11);
        drive(0, 0, 1, 1, 0, 0);
        chk("R7 mfr low byte", 16'h00C2, 2'b01);
        drive(0, 0, 1, 1, 0, 1);
        chk("R7 mfr high byte", 16'h0000, 2'b01);
        drive(0, 0, 1, 1, 1, 0);
        chk("R7 dev low byte", 16'h0012, 2'b01);
        drive(0, 0, 1, 1, 1, 1);
        chk("R7 dev high byte", 16'h0001, 2'b01);
        for (int b = 1; b < AW; b++) begin
            drive(0, 0, 0, 1, (1 << b) | (b & 1), 0);
            chk("R8 bad addr word", 16'hFFFF, 2'b11);
            drive(0, 0, 1, 1, (1 << b), b & 1);
            chk("R8 bad addr byte", 16'h00FF, 2'b01);
        end

        // R10: overwrite then read
        load(5, 16'h5AA5);
        drive(0, 0, 0, 0, 5, 0);
        chk("R10 reload word", 16'h5AA5, 2'b11);
        drive(0, 0, 1, 0, 5, 1);
        chk("R10 reload high half", 16'h005A, 2'b01);
        drive(0, 0, 0, 1, 0, 0);
        load(0, 16'h1234);
        drive(0, 0, 0, 1, 0, 0);
        chk("R6 array ignored", 16'h00C2, 2'b11);
        drive(1, 0, 0, 0, 0, 0);
        chk("R11 idle lanes zero", '0, 2'b00);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule